// File: doc/BRIEF.md
# Daisy-Chain Three-Wire Potentiometer Host

This block is the host side of a serial chain of digitally controlled potentiometer devices. Each device holds a 17-bit frame: one stack-select bit and two 8-bit wiper codes. The devices are wired in series, so each device's cascade output feeds the data input of the next. The host drives an enable line, a serial clock and a bidirectional data line. Every phase of the serial protocol is timed in system-clock cycles, and all of those counts are parameters.

A transaction starts with a one-cycle `start` pulse, and `readMode` selects the kind of transaction. In a write, the host loads `NUM_DEV` frames from `wrFrames` and raises `serEn`. It then shifts out exactly 17×`NUM_DEV` bits and drops `serEn`, which makes every device commit the frame it now holds. In a read, the host releases the data line so the far end of the chain loops back into the first device. It then clocks the same number of bits and records each returned bit. At the end the chain holds its original contents, and `rdFrames` holds a copy of them.

After `serEn` falls, `busy` stays high for a programmed recovery time. `done` pulses for one cycle when `busy` clears.

Top module: `chainhost_top`

## Requirements
- R1: Each transaction gives exactly 17×NUM_DEV rising edges on `serClk`, and `serClk` is never high while `serEn` is low.
- R2: In `wrFrames` and `rdFrames`, the frame sent or received first occupies the top 17 bits. Inside a frame, bit 16 is stack select, bits 15:8 are the potentiometer-1 code and bits 7:0 are the potentiometer-0 code, and each frame is sent from bit 16 down to bit 0. After a write, the device farthest from the host holds the first frame and the device nearest the host holds the last one.
- R3: While `serEn` is high, each high phase of `serClk` and each low phase between two rising edges lasts exactly HALF_CYC cycles.
- R4: In a write, `serDqOut` stops changing at least SETUP_CYC cycles before each rising `serClk` edge. It does not change within HALF_CYC cycles after that edge.
- R5: `serEn` rises exactly LEAD_CYC cycles before the first rising `serClk` edge, and `serClk` is low when `serEn` rises.
- R6: `serEn` falls exactly HALF_CYC+TAIL_CYC cycles after the last rising `serClk` edge. `busy` then stays high for exactly RECOV_CYC more cycles.
- R7: For a whole read transaction, `serDqOe` is 0. `rdFrames` then equals the frames the chain held, in arrival order, and the chain holds the same frames afterwards.
- R8: `busy` is high from the cycle after `start` is accepted. `done` is a single-cycle pulse in the first cycle that `busy` is low again.
- R9: A `start` pulse while `busy` is high has no effect on the running transaction, its data or its mode.
- R10: After reset, `busy`, `done`, `serEn` and `serClk` are 0, `serDqOe` is 1 and `rdFrames` is 0. A write transaction leaves `rdFrames` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted only while idle |
| readMode | input | 1 | 1 = circular read, 0 = write, sampled with `start` |
| wrFrames | input | 17×NUM_DEV | Frames to write, first-sent frame in the top bits |
| busy | output | 1 | Transaction in progress, including recovery |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| rdFrames | output | 17×NUM_DEV | Frames captured by the last read, first-arrived in the top bits |
| serClk | output | 1 | Serial clock to the chain |
| serEn | output | 1 | Serial enable to the chain, high during a transfer |
| serDqOut | output | 1 | Data driven toward the first device |
| serDqOe | output | 1 | Output enable for `serDqOut` |
| serDqIn | input | 1 | Resolved data line, looped back in reads |

## Verification
The bench models the chain as one 17-bit shift register per device. Each register shifts on rising `serClk` while `serEn` is high and commits when `serEn` falls. A monitor samples every output at the falling system-clock edge and timestamps each event in cycles.

The expected distances follow from one fact: every state lasts its programmed count.
- The first rising `serClk` comes LEAD_CYC cycles after `serEn` rises.
- Each `serDqOut` change lands SETUP_CYC cycles before the next rising edge.
- `serEn` falls HALF_CYC+TAIL_CYC cycles after the last rising edge.
- `busy` and the `done` pulse change RECOV_CYC cycles after that.

The bench compares these measured distances with exact values. It checks committed and captured frames only after `done` has been seen.

// File: rtl/chainhost_pkg.sv
package chainhost_pkg;

  // Fixed frame length of one device in the chain
  localparam int FRAME_W = 17;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_TAIL,
    ST_RECOV
  } seqState_t;

  // Strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic load;    // capture frames and mode at start
    logic shift;   // present the next outgoing bit
    logic sample;  // capture the looped-back bit before a rising edge
  } chainStrobe_t;

endpackage

// File: rtl/chainhost_ctrl.sv
module chainhost_ctrl
  import chainhost_pkg::*;
#(
  parameter int TOTAL_BITS = 51,
  parameter int HALF_CYC   = 29,
  parameter int SETUP_CYC  = 6,
  parameter int LEAD_CYC   = 10,
  parameter int TAIL_CYC   = 10,
  parameter int RECOV_CYC  = 25
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output chainStrobe_t strobes,
  output logic         serClk,
  output logic         serEn,
  output logic         busy,
  output logic         done
);

  localparam int MAX_AB  = (LEAD_CYC > HALF_CYC) ? LEAD_CYC : HALF_CYC;
  localparam int MAX_CD  = (TAIL_CYC > RECOV_CYC) ? TAIL_CYC : RECOV_CYC;
  localparam int MAX_DUR = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W   = $clog2(MAX_DUR + 1);
  localparam int BIT_W   = $clog2(TOTAL_BITS + 1);
  localparam int SHIFT_AT = HALF_CYC - SETUP_CYC - 1;

  seqState_t        state, stateNxt;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitCnt;
  int               durCur;
  logic             lastCyc;
  logic             lastBit;

  always_comb begin
    case (state)
      ST_LEAD:          durCur = LEAD_CYC;
      ST_LOW, ST_HIGH:  durCur = HALF_CYC;
      ST_TAIL:          durCur = TAIL_CYC;
      ST_RECOV:         durCur = RECOV_CYC;
      default:          durCur = 1;
    endcase
  end

  assign lastCyc = (int'(cnt) == durCur - 1);
  assign lastBit = (int'(bitCnt) == TOTAL_BITS);

  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE:  if (start)   stateNxt = ST_LEAD;
      ST_LEAD:  if (lastCyc) stateNxt = ST_HIGH;
      ST_HIGH:  if (lastCyc) stateNxt = lastBit ? ST_TAIL : ST_LOW;
      ST_LOW:   if (lastCyc) stateNxt = ST_HIGH;
      ST_TAIL:  if (lastCyc) stateNxt = ST_RECOV;
      ST_RECOV: if (lastCyc) stateNxt = ST_IDLE;
      default:               stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitCnt <= '0;
      done   <= 1'b0;
    end else begin
      state <= stateNxt;
      if (stateNxt != state || state == ST_IDLE) cnt <= '0;
      else                                      cnt <= cnt + 1'b1;
      if (strobes.load)                                 bitCnt <= '0;
      else if (stateNxt == ST_HIGH && state != ST_HIGH) bitCnt <= bitCnt + 1'b1;
      done <= (state == ST_RECOV) && lastCyc;
    end
  end

  always_comb begin
    strobes.load   = (state == ST_IDLE) && start;
    strobes.shift  = (state == ST_LOW) && (int'(cnt) == SHIFT_AT);
    strobes.sample = ((state == ST_LEAD) || (state == ST_LOW)) && lastCyc;
  end

  assign serClk = (state == ST_HIGH);
  assign serEn  = (state == ST_LEAD) || (state == ST_LOW) ||
                  (state == ST_HIGH) || (state == ST_TAIL);
  assign busy   = (state != ST_IDLE);

  AST_CLK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    serClk |-> serEn);                                            // R1
  AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    int'(bitCnt) <= TOTAL_BITS);                                  // R1
  AST_EN_RISE_CLK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serEn) |-> !serClk);                                    // R5
  AST_SHIFT_IN_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shift |-> (serEn && !serClk));                        // R4
  AST_EN_FALL_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(serEn) |-> busy);                                       // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);                                              // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);                                              // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !(state == ST_RECOV && lastCyc)) |=> busy); // R9

endmodule

// File: rtl/chainhost_dp.sv
module chainhost_dp
  import chainhost_pkg::*;
#(
  parameter int TOTAL_BITS = 51
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  chainStrobe_t          strobes,
  input  logic                  readMode,
  input  logic [TOTAL_BITS-1:0] wrFrames,
  input  logic                  serClk,
  input  logic                  serDqIn,
  output logic                  serDqOut,
  output logic                  serDqOe,
  output logic [TOTAL_BITS-1:0] rdFrames
);

  logic [TOTAL_BITS-1:0] txSr;
  logic [TOTAL_BITS-1:0] rxSr;
  logic                  rdMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSr   <= '0;
      rxSr   <= '0;
      rdMode <= 1'b0;
    end else begin
      if (strobes.load) begin
        txSr   <= wrFrames;
        rdMode <= readMode;
      end else if (strobes.shift) begin
        txSr <= {txSr[TOTAL_BITS-2:0], 1'b0};
      end
      if (strobes.sample && rdMode) rxSr <= {rxSr[TOTAL_BITS-2:0], serDqIn};
    end
  end

  assign serDqOut = txSr[TOTAL_BITS-1];
  assign serDqOe  = !rdMode;
  assign rdFrames = rxSr;

  AST_DQ_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (serClk && $past(serClk)) |-> $stable(serDqOut));            // R4
  AST_RX_HELD_IN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !rdMode |=> $stable(rxSr));                                   // R10
  AST_RX_HELD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    serClk |=> $stable(rxSr));                                    // R7

endmodule

// File: rtl/chainhost_top.sv
module chainhost_top
  import chainhost_pkg::*;
#(
  parameter int NUM_DEV   = 3,
  parameter int HALF_CYC  = 29,
  parameter int SETUP_CYC = 6,
  parameter int LEAD_CYC  = 10,
  parameter int TAIL_CYC  = 10,
  parameter int RECOV_CYC = 25,
  localparam int TOTAL_BITS = FRAME_W * NUM_DEV
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic                  readMode,
  input  logic [TOTAL_BITS-1:0] wrFrames,
  output logic                  busy,
  output logic                  done,
  output logic [TOTAL_BITS-1:0] rdFrames,
  output logic                  serClk,
  output logic                  serEn,
  output logic                  serDqOut,
  output logic                  serDqOe,
  input  logic                  serDqIn
);

  chainStrobe_t strobes;

  chainhost_ctrl #(
    .TOTAL_BITS(TOTAL_BITS),
    .HALF_CYC  (HALF_CYC),
    .SETUP_CYC (SETUP_CYC),
    .LEAD_CYC  (LEAD_CYC),
    .TAIL_CYC  (TAIL_CYC),
    .RECOV_CYC (RECOV_CYC)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobes(strobes),
    .serClk (serClk),
    .serEn  (serEn),
    .busy   (busy),
    .done   (done)
  );

  chainhost_dp #(
    .TOTAL_BITS(TOTAL_BITS)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .readMode(readMode),
    .wrFrames(wrFrames),
    .serClk  (serClk),
    .serDqIn (serDqIn),
    .serDqOut(serDqOut),
    .serDqOe (serDqOe),
    .rdFrames(rdFrames)
  );

endmodule

// File: tb/chainhost_top_tb_top.sv
`timescale 1ns/1ps
module chainhost_top_tb_top;

  localparam int ND    = 3;
  localparam int FW    = 17;
  localparam int T     = FW * ND;
  localparam int HALF  = 29;
  localparam int SETUP = 6;
  localparam int LEAD  = 10;
  localparam int TAIL  = 10;
  localparam int RECOV = 25;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic         readMode = 1'b0;
  logic [T-1:0] wrFrames = '0;
  logic         busy, done, serClk, serEn, serDqOut, serDqOe;
  logic [T-1:0] rdFrames;
  logic         lineDq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  chainhost_top #(
    .NUM_DEV(ND), .HALF_CYC(HALF), .SETUP_CYC(SETUP),
    .LEAD_CYC(LEAD), .TAIL_CYC(TAIL), .RECOV_CYC(RECOV)
  ) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .readMode(readMode),
    .wrFrames(wrFrames), .busy(busy), .done(done), .rdFrames(rdFrames),
    .serClk(serClk), .serEn(serEn), .serDqOut(serDqOut),
    .serDqOe(serDqOe), .serDqIn(lineDq)
  );

  // Chain model: device 0 nearest the host
  logic [FW-1:0] devSr [ND];
  logic [FW-1:0] devHeld [ND];

  assign lineDq = serDqOe ? serDqOut : devSr[ND-1][FW-1];

  initial begin
    for (int k = 0; k < ND; k++) begin
      devSr[k]   = '0;
      devHeld[k] = '0;
    end
  end

  always @(posedge serClk) begin
    if (serEn) begin
      for (int k = 0; k < ND; k++)
        devSr[k] <= {devSr[k][FW-2:0], (k == 0) ? lineDq : devSr[k-1][FW-1]};
    end
  end

  always @(negedge serEn) begin
    for (int k = 0; k < ND; k++) devHeld[k] <= devSr[k];
  end

  // Timing monitor, sampled at the falling system-clock edge
  int cyc = 0;
  logic pClk = 0, pEn = 0, pDq = 0, pBusy = 0;
  int riseCnt, enRiseCyc, enFallCyc, lastRiseCyc, fallCyc, dqChgCyc;
  int leadMeas, tailMeas, recovMeas, minSetup, minHold;
  int highMin, highMax, lowMin, lowMax;
  int doneCnt, doneMis, oeBad, clkNoEn;
  bit holdArmed, txRead;

  task automatic clearStats();
    riseCnt = 0; leadMeas = -1; tailMeas = -1; recovMeas = -1;
    minSetup = 1000000; minHold = 1000000; holdArmed = 0;
    highMin = 1000000; highMax = -1; lowMin = 1000000; lowMax = -1;
    doneCnt = 0; doneMis = 0; oeBad = 0; clkNoEn = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (serClk && !pClk) begin
      riseCnt++;
      if (riseCnt == 1) leadMeas = cyc - enRiseCyc;
      else begin
        if (cyc - fallCyc < lowMin) lowMin = cyc - fallCyc;
        if (cyc - fallCyc > lowMax) lowMax = cyc - fallCyc;
      end
      if (!txRead && (cyc - dqChgCyc < minSetup)) minSetup = cyc - dqChgCyc;
      lastRiseCyc = cyc;
      holdArmed = 1;
    end
    if (!serClk && pClk) begin
      if (cyc - lastRiseCyc < highMin) highMin = cyc - lastRiseCyc;
      if (cyc - lastRiseCyc > highMax) highMax = cyc - lastRiseCyc;
      fallCyc = cyc;
    end
    if (serDqOut != pDq) begin
      if (holdArmed && busy && !txRead && (cyc - lastRiseCyc < minHold))
        minHold = cyc - lastRiseCyc;
      holdArmed = 0;
      dqChgCyc = cyc;
    end
    if (serEn && !pEn) enRiseCyc = cyc;
    if (!serEn && pEn) begin
      tailMeas = cyc - lastRiseCyc;
      enFallCyc = cyc;
    end
    if (!busy && pBusy) recovMeas = cyc - enFallCyc;
    if (done) begin
      doneCnt++;
      if (!(!busy && pBusy)) doneMis++;
    end
    if (busy && txRead && serDqOe) oeBad++;
    if (serClk && !serEn) clkNoEn++;
    pClk = serClk; pEn = serEn; pDq = serDqOut; pBusy = busy;
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual cycles=%0d expected<150000", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkWide(input string req, input logic [T-1:0] act, input logic [T-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] frameOf(input logic [T-1:0] v, input int j);
    return v[T-1-FW*j -: FW];
  endfunction

  function automatic logic [FW-1:0] mkFrame(input logic ss, input logic [7:0] p1, input logic [7:0] p0);
    return {ss, p1, p0};
  endfunction

  task automatic launch(input logic rd, input logic [T-1:0] data);
    @(posedge clk); #1;
    readMode = rd; wrFrames = data; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0; wrFrames = '0; readMode = 1'b0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
  endtask

  task automatic checkTiming(input string tag);
    check({tag, " R1 edge count"}, riseCnt, T);
    check({tag, " R1 clk only with enable"}, clkNoEn, 0);
    check({tag, " R3 high min"}, highMin, HALF);
    check({tag, " R3 high max"}, highMax, HALF);
    check({tag, " R3 low min"}, lowMin, HALF);
    check({tag, " R3 low max"}, lowMax, HALF);
    check({tag, " R5 lead"}, leadMeas, LEAD);
    check({tag, " R6 tail"}, tailMeas, HALF + TAIL);
    check({tag, " R6 recovery"}, recovMeas, RECOV);
    check({tag, " R8 done count"}, doneCnt, 1);
    check({tag, " R8 done aligned"}, doneMis, 0);
  endtask

  task automatic doWrite(input string tag, input logic [T-1:0] data);
    logic [T-1:0] rdBefore;
    rdBefore = rdFrames;
    clearStats(); txRead = 0;
    launch(1'b0, data);
    check({tag, " R8 busy after start"}, busy, 1'b1);
    waitDone();
    checkTiming(tag);
    check({tag, " R4 setup >= SETUP"}, minSetup >= SETUP, 1'b1);
    check({tag, " R4 hold >= HALF"}, minHold >= HALF, 1'b1);
    for (int k = 0; k < ND; k++)
      check({tag, " R2 device frame"}, devHeld[k], frameOf(data, ND - 1 - k));
    checkWide({tag, " R10 rdFrames kept"}, rdFrames, rdBefore);
  endtask

  task automatic doRead(input string tag, input logic [T-1:0] expect_);
    clearStats(); txRead = 1;
    launch(1'b1, {T{1'b1}});
    waitDone();
    checkTiming(tag);
    check({tag, " R7 oe released"}, oeBad, 0);
    checkWide({tag, " R7 captured frames"}, rdFrames, expect_);
    for (int k = 0; k < ND; k++)
      check({tag, " R7 chain restored"}, devHeld[k], frameOf(expect_, ND - 1 - k));
    txRead = 0;
  endtask

  task automatic testReset();
    check("R10 busy at reset", busy, 1'b0);
    check("R10 done at reset", done, 1'b0);
    check("R10 serEn at reset", serEn, 1'b0);
    check("R10 serClk at reset", serClk, 1'b0);
    check("R10 oe at reset", serDqOe, 1'b1);
    checkWide("R10 rdFrames at reset", rdFrames, '0);
  endtask

  task automatic testStartWhileBusy(input logic [T-1:0] data);
    logic [T-1:0] rdBefore;
    rdBefore = rdFrames;
    clearStats(); txRead = 0;
    launch(1'b0, data);
    repeat (300) @(posedge clk);
    launch(1'b1, ~data);
    waitDone();
    check("R9 edge count", riseCnt, T);
    check("R9 single done", doneCnt, 1);
    for (int k = 0; k < ND; k++)
      check("R9 device frame", devHeld[k], frameOf(data, ND - 1 - k));
    checkWide("R9 read mode ignored", rdFrames, rdBefore);
    repeat (5) @(negedge clk);
    check("R9 stays idle", busy, 1'b0);
  endtask

  logic [T-1:0] patA, patB, patC;

  initial begin
    clearStats(); txRead = 0;
    enRiseCyc = 0; enFallCyc = 0; lastRiseCyc = 0; fallCyc = 0; dqChgCyc = 0;
    patA = {mkFrame(1'b1, 8'hA5, 8'h3C), mkFrame(1'b0, 8'h01, 8'h80), mkFrame(1'b1, 8'hFF, 8'h00)};
    patB = {T{1'b1}};
    patC = {mkFrame(1'b0, 8'h55, 8'hAA), mkFrame(1'b1, 8'h7E, 8'h81), mkFrame(1'b0, 8'h00, 8'hFF)};
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    testReset();
    doWrite("write A", patA);
    doRead("read A", patA);
    doWrite("write ones", patB);
    doRead("read ones", patB);
    doWrite("write zeros", '0);
    doWrite("write C", patC);
    doRead("read C", patC);
    testStartWhileBusy(patA);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule